// File: doc/BRIEF.md
# Supply-Pulse Key Decoder

This block turns a train of voltage pulses on a supply pin into register and mode selections for a fuse-programming engine. Two comparator flags arrive already synchronized: one says the supply is at least at the mid level, the other says it is at least at the high level. A qualifier measures each excursion above the low level. It keeps only pulses held long enough that also follow a long enough low gap. Each surviving pulse becomes a mid, key-high or blow token.

A state machine walks those tokens through the key table. The keys share prefixes. Two highs already pick a Try register, yet four or eleven further mids and a high change that choice. Each selection is therefore announced as soon as it is complete, with a one-cycle strobe at the end of the closing high pulse, and later tokens may replace it. Mid pulses that follow a selection are passed on as address strobes. Blow-length highs are passed on as fuse-blow requests while a Blow/Read register is selected. A sequence that fits no key parks the machine until the next supply-cycle reset. When the lock fuse is set, only the fuse-checking register can be reached. Code counting and fuse storage sit outside.

Top module: `supply_key_decoder`

## Requirements
- R1: After reset no strobe is active, `sel_reg` is 0 and `sel_blow` is 0.
- R2: A pulse whose active time is below ACT_MIN cycles is a glitch and changes nothing. A pulse counts as high when the high flag was set for at least ACT_MIN cycles, otherwise as mid when active for at least ACT_MIN cycles.
- R3: A pulse that starts before the low gap since the previous pulse (or since reset) reaches GAP_MIN cycles is discarded.
- R4: The key high,high selects register code 0 (positive trim, counting up) in Try mode (`sel_blow`=0). `sel_stb` is high for exactly one cycle, the cycle after the first clock edge that samples the supply low again.
- R5: high,mid,high,high selects code 1 (negative trim, up). high,mid,mid,mid,high selects code 4 (fuse checking). Both are in Try mode.
- R6: Four mids and a high after a code-0 or code-1 selection select code 2 or code 3 (the matching down-counting registers), still in Try mode.
- R7: Eleven mids and a high in Blow/Read mode (`sel_blow`=1) select the following. After high,high they select code 5 (magnitude). After high,mid,high they select code 6 (sign). After the fuse-checking key they select code 7 (output/lock).
- R8: Every mid pulse after a selection, tentative ones included, gives a one-cycle `addr_stb`. No two strobes are ever active together.
- R9: In Blow/Read mode a high pulse of at least BLOW_MIN cycles gives a one-cycle `blow_stb`. A key-length high in that mode, or a blow-length high anywhere else, is a key mismatch.
- R10: A token sequence that matches no key leaves the decoder dead. It gives no further strobe until reset.
- R11: While `lock_set` is high, any key completing to a code other than 4 gives no strobe and leaves the decoder dead. Code 4 is still selected.
- R12: `sel_reg` and `sel_blow` change only together with `sel_stb` and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted on each supply cycle |
| lvl_mid | input | 1 | Supply at or above the mid level (synchronized) |
| lvl_high | input | 1 | Supply at or above the high level (synchronized) |
| lock_set | input | 1 | Lock fuse is blown |
| sel_stb | output | 1 | One-cycle strobe: a new selection took effect |
| sel_reg | output | 3 | Selected register code (0 to 7, see R4 to R7) |
| sel_blow | output | 1 | 1 = Blow/Read mode, 0 = Try mode |
| addr_stb | output | 1 | One-cycle strobe per forwarded mid pulse |
| blow_stb | output | 1 | One-cycle strobe per blow request |

## Verification
While a Try register is selected, one mid pulse does two jobs. It is forwarded as an address step, and it also advances the count that can turn the key into a down-counting or Blow/Read selection. The bench provokes this by sending four or eleven mids after a two-high key and then a closing high. Every mid must show up as an address strobe in order, and the closing high must show up as exactly one selection strobe with the new code. Each strobe is matched in sequence against an expected queue, so a mid that is swallowed by the key count, or a selection that comes one pulse early, is reported as a wrong or unexpected item.

// File: rtl/supply_key_decoder.sv
module supply_key_decoder #(
  parameter int ACT_MIN  = 20,
  parameter int GAP_MIN  = 20,
  parameter int BLOW_MIN = 90
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl_mid,
  input  logic       lvl_high,
  input  logic       lock_set,
  output logic       sel_stb,
  output logic [2:0] sel_reg,
  output logic       sel_blow,
  output logic       addr_stb,
  output logic       blow_stb
);
  localparam int CW = $clog2(BLOW_MIN + 1);
  localparam int GW = $clog2(GAP_MIN + 1);

  localparam logic [2:0] R_POS_UP = 3'd0;
  localparam logic [2:0] R_NEG_UP = 3'd1;
  localparam logic [2:0] R_POS_DN = 3'd2;
  localparam logic [2:0] R_NEG_DN = 3'd3;
  localparam logic [2:0] R_FUSE   = 3'd4;
  localparam logic [2:0] R_MAG    = 3'd5;
  localparam logic [2:0] R_SIGN   = 3'd6;
  localparam logic [2:0] R_OUTLK  = 3'd7;

  typedef enum logic [2:0] {ST_IDLE, ST_H, ST_HMH, ST_TRY, ST_BLOW, ST_DEAD} st_t;

  wire act = lvl_mid | lvl_high;

  logic          in_pulse, gap_ok;
  logic [CW-1:0] act_cnt, hi_cnt;
  logic [GW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse <= 1'b0;
      gap_ok   <= 1'b0;
      act_cnt  <= '0;
      hi_cnt   <= '0;
      gap_cnt  <= '0;
    end else if (act) begin
      gap_cnt <= '0;
      if (!in_pulse) begin
        in_pulse <= 1'b1;
        gap_ok   <= (gap_cnt >= GW'(GAP_MIN));
        act_cnt  <= CW'(1);
        hi_cnt   <= lvl_high ? CW'(1) : '0;
      end else begin
        if (act_cnt != CW'(BLOW_MIN)) act_cnt <= act_cnt + 1'b1;
        if (lvl_high && hi_cnt != CW'(BLOW_MIN)) hi_cnt <= hi_cnt + 1'b1;
      end
    end else begin
      in_pulse <= 1'b0;
      if (gap_cnt < GW'(GAP_MIN)) gap_cnt <= gap_cnt + 1'b1;
    end
  end

  wire p_end    = in_pulse & ~act & gap_ok;
  wire tok_blow = p_end & (hi_cnt >= CW'(BLOW_MIN));
  wire tok_high = p_end & (hi_cnt >= CW'(ACT_MIN)) & (hi_cnt < CW'(BLOW_MIN));
  wire tok_mid  = p_end & (hi_cnt < CW'(ACT_MIN)) & (act_cnt >= CW'(ACT_MIN));

  st_t        state, nxt_state;
  logic [3:0] cnt, nxt_cnt, cnt_inc;
  logic       want, w_blow, do_sel, do_addr, do_blow, nxt_mode;
  logic [2:0] w_id, nxt_reg;

  assign cnt_inc = (cnt == 4'd12) ? cnt : cnt + 4'd1;

  always_comb begin
    nxt_state = state;
    nxt_cnt   = cnt;
    want      = 1'b0;
    w_id      = R_POS_UP;
    w_blow    = 1'b0;
    do_addr   = 1'b0;
    do_blow   = 1'b0;
    do_sel    = 1'b0;
    nxt_reg   = sel_reg;
    nxt_mode  = sel_blow;
    case (state)
      ST_IDLE: begin
        if (tok_high) begin nxt_state = ST_H; nxt_cnt = '0; end
        else if (tok_mid || tok_blow) nxt_state = ST_DEAD;
      end
      ST_H: begin
        if (tok_mid) nxt_cnt = cnt_inc;
        else if (tok_blow) nxt_state = ST_DEAD;
        else if (tok_high) begin
          if (cnt == 4'd0) begin want = 1'b1; w_id = R_POS_UP; end
          else if (cnt == 4'd1) begin nxt_state = ST_HMH; nxt_cnt = '0; end
          else if (cnt == 4'd3) begin want = 1'b1; w_id = R_FUSE; end
          else nxt_state = ST_DEAD;
        end
      end
      ST_HMH: begin
        if (tok_mid) nxt_cnt = cnt_inc;
        else if (tok_blow) nxt_state = ST_DEAD;
        else if (tok_high) begin
          if (cnt == 4'd0) begin want = 1'b1; w_id = R_NEG_UP; end
          else if (cnt == 4'd11) begin want = 1'b1; w_id = R_SIGN; w_blow = 1'b1; end
          else nxt_state = ST_DEAD;
        end
      end
      ST_TRY: begin
        if (tok_mid) begin nxt_cnt = cnt_inc; do_addr = 1'b1; end
        else if (tok_blow) nxt_state = ST_DEAD;
        else if (tok_high) begin
          if (cnt == 4'd4 && sel_reg == R_POS_UP) begin want = 1'b1; w_id = R_POS_DN; end
          else if (cnt == 4'd4 && sel_reg == R_NEG_UP) begin want = 1'b1; w_id = R_NEG_DN; end
          else if (cnt == 4'd11 && sel_reg == R_POS_UP) begin want = 1'b1; w_id = R_MAG; w_blow = 1'b1; end
          else if (cnt == 4'd11 && sel_reg == R_FUSE) begin want = 1'b1; w_id = R_OUTLK; w_blow = 1'b1; end
          else nxt_state = ST_DEAD;
        end
      end
      ST_BLOW: begin
        if (tok_mid) do_addr = 1'b1;
        else if (tok_blow) do_blow = 1'b1;
        else if (tok_high) nxt_state = ST_DEAD;
      end
      default: nxt_state = ST_DEAD;
    endcase
    if (want) begin
      if (lock_set && w_id != R_FUSE) nxt_state = ST_DEAD;
      else begin
        do_sel    = 1'b1;
        nxt_reg   = w_id;
        nxt_mode  = w_blow;
        nxt_state = w_blow ? ST_BLOW : ST_TRY;
        nxt_cnt   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sel_reg  <= R_POS_UP;
      sel_blow <= 1'b0;
      sel_stb  <= 1'b0;
      addr_stb <= 1'b0;
      blow_stb <= 1'b0;
    end else begin
      state    <= nxt_state;
      cnt      <= nxt_cnt;
      sel_reg  <= nxt_reg;
      sel_blow <= nxt_mode;
      sel_stb  <= do_sel;
      addr_stb <= do_addr;
      blow_stb <= do_blow;
    end
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_stb, addr_stb, blow_stb}));
  assert_sel_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb |=> !sel_stb);
  assert_blow_in_blow_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blow_stb |-> sel_blow);
  assert_lock_fuse_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_stb && $past(lock_set)) |-> (sel_reg == R_FUSE));
  assert_dead_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEAD) |=> (state == ST_DEAD) && !sel_stb && !addr_stb && !blow_stb);
  assert_sel_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel_reg != $past(sel_reg)) || (sel_blow != $past(sel_blow))) |-> sel_stb);
endmodule

// File: tb/supply_key_decoder_tb_top.sv
module supply_key_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 30;
  localparam int GAP = 30;
  localparam int BLOW_LEN = 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lvl_mid = 1'b0, lvl_high = 1'b0, lock_set = 1'b0;
  logic sel_stb, sel_blow, addr_stb, blow_stb;
  logic [2:0] sel_reg;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int exp_q[$];
  string req_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  supply_key_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .lvl_mid(lvl_mid), .lvl_high(lvl_high),
    .lock_set(lock_set), .sel_stb(sel_stb), .sel_reg(sel_reg),
    .sel_blow(sel_blow), .addr_stb(addr_stb), .blow_stb(blow_stb)
  );

  // item code: kind*16 + mode*8 + reg; kind 1 = select, 2 = address, 3 = blow
  always @(negedge clk) begin
    if (rst_n && (sel_stb || addr_stb || blow_stb)) begin
      int obs;
      int exp;
      string rq;
      obs = sel_stb ? (16 + (sel_blow ? 8 : 0) + int'(sel_reg)) : (addr_stb ? 32 : 48);
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 R11 unexpected strobe: actual code %0d expected none", obs);
      end else begin
        exp = exp_q.pop_front();
        rq = req_q.pop_front();
        if (obs != exp) begin
          n_fail++;
          $display("FAIL %s strobe mismatch: actual code %0d expected %0d", rq, obs, exp);
        end
      end
    end
  end

  task automatic pulse(input int lvl, input int len, input int gap);
    @(negedge clk);
    lvl_mid = 1'b1;
    lvl_high = (lvl == 2);
    repeat (len) @(negedge clk);
    lvl_mid = 1'b0;
    lvl_high = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic hi();  pulse(2, PW, GAP); endtask
  task automatic mid(); pulse(1, PW, GAP); endtask
  task automatic blow(); pulse(2, BLOW_LEN, GAP); endtask

  task automatic exp_sel(input int rg, input int md, input string rq);
    exp_q.push_back(16 + md * 8 + rg);
    req_q.push_back(rq);
  endtask

  task automatic mids(input int n, input bit addr, input string rq);
    for (int i = 0; i < n; i++) begin
      if (addr) begin exp_q.push_back(32); req_q.push_back(rq); end
      mid();
    end
  endtask

  task automatic settle(input string rq);
    repeat (5) @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL %s missing strobe: actual pending %0d expected 0", rq, exp_q.size());
    end
    exp_q.delete();
    req_q.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    lvl_mid = 1'b0;
    lvl_high = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic check_hold(input int rg, input int md, input string rq);
    n_tests++;
    if (int'(sel_reg) != rg || int'(sel_blow) != md) begin
      n_fail++;
      $display("FAIL %s held selection: actual %0d/%0d expected %0d/%0d",
               rq, sel_reg, sel_blow, rg, md);
    end
  endtask

  initial begin
    do_reset();
    // R1: reset state
    n_tests++;
    if (sel_stb || addr_stb || blow_stb || sel_reg != 3'd0 || sel_blow) begin
      n_fail++;
      $display("FAIL R1 reset state: actual %b%b%b reg %0d mode %0d expected 000 reg 0 mode 0",
               sel_stb, addr_stb, blow_stb, sel_reg, sel_blow);
    end

    // R4 and R8: HH then addresses
    hi(); exp_sel(0, 0, "R4"); hi();
    mids(2, 1, "R8");
    check_hold(0, 0, "R12");
    settle("R4");

    // R2: glitches ignored
    do_reset();
    hi(); pulse(2, 5, GAP); pulse(1, 5, GAP); exp_sel(0, 0, "R2"); hi();
    settle("R2");

    // R3: pulse after short gap discarded
    do_reset();
    pulse(2, PW, 5); pulse(2, PW, GAP); exp_sel(0, 0, "R3"); hi();
    settle("R3");

    // R5: negative up, fuse check
    do_reset();
    hi(); mid(); hi(); exp_sel(1, 0, "R5"); hi();
    settle("R5");
    do_reset();
    hi(); mids(3, 0, "R5"); exp_sel(4, 0, "R5"); hi();
    mids(1, 1, "R8");
    settle("R5");

    // R6: down-counting registers (mids serve as addresses and key count)
    do_reset();
    hi(); exp_sel(0, 0, "R6"); hi(); mids(4, 1, "R8"); exp_sel(2, 0, "R6"); hi();
    settle("R6");
    do_reset();
    hi(); mid(); hi(); exp_sel(1, 0, "R6"); hi(); mids(4, 1, "R8"); exp_sel(3, 0, "R6"); hi();
    settle("R6");

    // R7 and R9: blow/read registers
    do_reset();
    hi(); exp_sel(0, 0, "R7"); hi(); mids(11, 1, "R8"); exp_sel(5, 1, "R7"); hi();
    mids(1, 1, "R9");
    exp_q.push_back(48); req_q.push_back("R9"); blow();
    mids(1, 1, "R9");
    check_hold(5, 1, "R12");
    settle("R7");
    do_reset();
    hi(); mid(); hi(); mids(11, 0, "R7"); exp_sel(6, 1, "R7"); hi();
    settle("R7");
    do_reset();
    hi(); mids(3, 0, "R7"); exp_sel(4, 0, "R7"); hi(); mids(11, 1, "R8"); exp_sel(7, 1, "R7"); hi();
    settle("R7");

    // R9: key-length high in blow mode kills decoder
    do_reset();
    hi(); mid(); hi(); mids(11, 0, "R9"); exp_sel(6, 1, "R9"); hi();
    hi(); mid(); blow();
    settle("R9");
    // R9: blow-length pulse in Try mode is a mismatch
    do_reset();
    hi(); exp_sel(0, 0, "R9"); hi(); blow(); mid();
    settle("R9");

    // R10: unmatched sequence, then a valid key is ignored
    do_reset();
    hi(); mids(2, 0, "R10"); hi(); hi(); hi(); mid();
    check_hold(0, 0, "R10");
    settle("R10");

    // R11: lock set
    do_reset();
    lock_set = 1'b1;
    hi(); hi(); mid();
    settle("R11");
    do_reset();
    hi(); mids(3, 0, "R11"); exp_sel(4, 0, "R11"); hi(); mids(2, 1, "R11");
    settle("R11");
    do_reset();
    hi(); mid(); hi(); mids(11, 0, "R11"); hi(); mid(); blow();
    check_hold(0, 0, "R11");
    settle("R11");
    lock_set = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule